// File: doc/BRIEF.md
# Fault Escalation and Status Unit

This block sits beside a processor's exception logic. The pipeline reports a fault as a one-cycle strobe with a five-bit cause code. The block records the cause as a sticky bit in one of three status registers: memory management, bus or usage. In the same cycle it decides which handler has to run.

A fault normally goes to the handler of its own category, whose priority software can set. If that handler is disabled, or the fault's priority cannot beat the current execution priority, the block sends the fault to the hard fault handler instead. The hard fault handler has a fixed priority. This covers two cases: a fault raised inside its own handler, and a fault raised inside any other handler of equal or higher urgency.

Software reads the three status registers. It clears bits through a small write port on which a one clears a bit and a zero leaves it alone.

Top module: `fault_escalation_unit`

## Requirements
- R1: After reset, all three status registers are zero, `req_valid` is 0 and `req_handler` is 0 (no handler).
- R2: The cause code is `{category[1:0], index[2:0]}`, and category 0 is memory management. Memory management index 0 to 4 sets `mm_status` bit 0 to 4. The bits are: instruction access violation (also raised for execute-never accesses whether or not protection is enabled), data access violation, stacking, unstacking and lazy floating-point save.
- R3: Category 1 is bus. Bus index 0 to 5 sets `bus_status` bit 0 to 5. The bits are: stacking, unstacking, instruction prefetch, lazy floating-point save, precise data and imprecise data.
- R4: Category 2 is usage. Usage index 0 to 5 sets `use_status` bit 0 to 5. The bits are: coprocessor access, undefined instruction, invalid state (raised on any attempt to leave the single supported instruction set), invalid return value, unaligned access and divide by zero.
- R5: Category 3, memory management index 5 to 7, and bus or usage index 6 to 7 are invalid codes. An invalid code sets no status bit and raises no request.
- R6: A valid fault whose handler is enabled and whose priority is strictly numerically less than `cur_pri` raises a request one clock later. That request carries handler code 1, 2 or 3 (memory management, bus or usage) and `req_escalated` = 0.
- R7: A valid fault whose priority is equal to or greater than `cur_pri` is escalated. The request carries handler code 4 (hard fault) and `req_escalated` = 1.
- R8: A valid fault whose handler enable is 0 is escalated to handler code 4, whatever its priority.
- R9: Status bits are sticky. Each one stays set, and later faults add bits, until software clears it.
- R10: A write with `wr_sel` 0, 1 or 2 (memory management, bus, usage) clears each bit of that register that has a one in `wr_data`. A zero bit, a bit above the register's width, and `wr_sel` = 3 have no effect.
- R11: When a fault sets a bit in the same cycle that a write clears it, the bit ends up set.
- R12: `req_valid` is high for exactly one cycle per accepted fault. Otherwise it is low, and `req_handler` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_valid | input | 1 | Fault strobe |
| fault_cause | input | 5 | Category (bits 4:3) and index (bits 2:0) |
| cur_pri | input | PW+1 | Current execution priority; 2**PW means thread level |
| hnd_en | input | 3 | Handler enables: bit 0 memory management, 1 bus, 2 usage |
| pri_mem | input | PW | Memory management handler priority |
| pri_bus | input | PW | Bus fault handler priority |
| pri_use | input | PW | Usage fault handler priority |
| wr_en | input | 1 | Status write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 6 | Write-one-to-clear mask |
| req_valid | output | 1 | Handler request pulse |
| req_handler | output | 3 | 0 none, 1 memory management, 2 bus, 3 usage, 4 hard fault |
| req_escalated | output | 1 | Request was redirected to hard fault |
| mm_status | output | 5 | Memory management status |
| bus_status | output | 6 | Bus status |
| use_status | output | 6 | Usage status |

## Verification
The bench sweeps every cause code against every current priority and every handler priority, with the handler enabled and again disabled. The equal-priority boundary is where this block is most fragile. A design that compares with less-or-equal would let a handler preempt itself instead of escalating, and a design that ignores the enable would dispatch to a disabled handler. The out-of-range indices must leave every register untouched, because a decoder that only checks the category would set a phantom bit. The clear port is tested with zero masks, foreign selects, over-width bits and a clear that collides with a fault, and the collision must leave the bit set.

// File: rtl/fault_pkg.sv
// Shared encodings for the fault escalation unit.
// Assumes cause codes are {category, index} with three valid categories.
package fault_pkg;
    localparam int MAXBITS  = 6;
    localparam int MEM_BITS = 5;
    localparam int BUS_BITS = 6;
    localparam int USE_BITS = 6;

    localparam logic [1:0] CAT_MEM = 2'd0;
    localparam logic [1:0] CAT_BUS = 2'd1;
    localparam logic [1:0] CAT_USE = 2'd2;

    typedef enum logic [2:0] {
        HND_NONE  = 3'd0,
        HND_MEM   = 3'd1,
        HND_BUS   = 3'd2,
        HND_USE   = 3'd3,
        HND_HARD  = 3'd4
    } handler_e;
endpackage

// File: rtl/fault_cause_decode.sv
// Splits a cause code into category and a one-hot status bit.
// Assumes nothing about timing: purely combinational.
module fault_cause_decode
    import fault_pkg::*;
(
    input  logic [4:0]         cause,
    output logic               ok,
    output logic [1:0]         cat,
    output logic [MAXBITS-1:0] onehot
);
    logic [2:0] idx;

    // Validate the index against the width of its category and form the bit.
    always_comb begin
        cat = cause[4:3];
        idx = cause[2:0];
        case (cat)
            CAT_MEM: ok = (32'(idx) < MEM_BITS);
            CAT_BUS: ok = (32'(idx) < BUS_BITS);
            CAT_USE: ok = (32'(idx) < USE_BITS);
            default: ok = 1'b0;
        endcase
        onehot = ok ? (MAXBITS'(1) << idx) : '0;
    end
endmodule

// File: rtl/fault_escalate.sv
// Chooses the handler for a fault: its own handler when enabled and
// strictly more urgent than the current level, hard fault otherwise.
// Assumes a smaller priority number is more urgent.
module fault_escalate
    import fault_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic [1:0]      cat,
    input  logic [PW:0]     cur_pri,
    input  logic [2:0]      en,
    input  logic [PW-1:0]   pri_mem,
    input  logic [PW-1:0]   pri_bus,
    input  logic [PW-1:0]   pri_use,
    output handler_e        hnd,
    output logic            esc
);
    logic [PW-1:0] fpri;
    logic          fen;
    handler_e      own;
    logic          wins;

    // Select the category's priority and enable, then compare.
    always_comb begin
        case (cat)
            CAT_MEM: begin fpri = pri_mem; fen = en[0]; own = HND_MEM; end
            CAT_BUS: begin fpri = pri_bus; fen = en[1]; own = HND_BUS; end
            CAT_USE: begin fpri = pri_use; fen = en[2]; own = HND_USE; end
            default: begin fpri = '0;      fen = 1'b0;  own = HND_NONE; end
        endcase
        wins = fen && ({1'b0, fpri} < cur_pri);
        hnd  = wins ? own : HND_HARD;
        esc  = !wins;
    end
endmodule

// File: rtl/fault_status_reg.sv
// One sticky status register with write-one-to-clear access.
// Assumes a set and a clear of the same bit in one cycle leaves it set.
module fault_status_reg #(
    parameter int         W   = 6,
    parameter logic [1:0] SEL = 2'd0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr;

    // Build the clear mask for this register only.
    always_comb clr = (wr_en && (wr_sel == SEL)) ? wr_data : '0;

    // Clear first, then set, so a new fault always lands.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set_vec;
    end
endmodule

// File: rtl/fault_escalation_unit.sv
// Top: records fault causes in three sticky registers and issues a
// registered handler request, escalating to hard fault when needed.
// Assumes at most one fault per cycle; request appears one clock later.
module fault_escalation_unit
    import fault_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fault_valid,
    input  logic [4:0]           fault_cause,
    input  logic [PW:0]          cur_pri,
    input  logic [2:0]           hnd_en,
    input  logic [PW-1:0]        pri_mem,
    input  logic [PW-1:0]        pri_bus,
    input  logic [PW-1:0]        pri_use,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [MAXBITS-1:0]   wr_data,
    output logic                 req_valid,
    output logic [2:0]           req_handler,
    output logic                 req_escalated,
    output logic [MEM_BITS-1:0]  mm_status,
    output logic [BUS_BITS-1:0]  bus_status,
    output logic [USE_BITS-1:0]  use_status
);
    logic               dec_ok;
    logic [1:0]         dec_cat;
    logic [MAXBITS-1:0] dec_bit;
    handler_e           sel_hnd;
    logic               sel_esc;
    logic               accept;
    logic [MAXBITS-1:0] set_mem, set_bus, set_use;

    fault_cause_decode u_dec (
        .cause (fault_cause),
        .ok    (dec_ok),
        .cat   (dec_cat),
        .onehot(dec_bit)
    );

    fault_escalate #(.PW(PW)) u_esc (
        .cat    (dec_cat),
        .cur_pri(cur_pri),
        .en     (hnd_en),
        .pri_mem(pri_mem),
        .pri_bus(pri_bus),
        .pri_use(pri_use),
        .hnd    (sel_hnd),
        .esc    (sel_esc)
    );

    // Steer the decoded bit to the register of its category.
    always_comb begin
        accept  = fault_valid && dec_ok;
        set_mem = (accept && dec_cat == CAT_MEM) ? dec_bit : '0;
        set_bus = (accept && dec_cat == CAT_BUS) ? dec_bit : '0;
        set_use = (accept && dec_cat == CAT_USE) ? dec_bit : '0;
    end

    fault_status_reg #(.W(MEM_BITS), .SEL(CAT_MEM)) u_mm (
        .clk(clk), .rst_n(rst_n), .set_vec(set_mem[MEM_BITS-1:0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data[MEM_BITS-1:0]),
        .q(mm_status)
    );

    fault_status_reg #(.W(BUS_BITS), .SEL(CAT_BUS)) u_bus (
        .clk(clk), .rst_n(rst_n), .set_vec(set_bus[BUS_BITS-1:0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data[BUS_BITS-1:0]),
        .q(bus_status)
    );

    fault_status_reg #(.W(USE_BITS), .SEL(CAT_USE)) u_use (
        .clk(clk), .rst_n(rst_n), .set_vec(set_use[USE_BITS-1:0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data[USE_BITS-1:0]),
        .q(use_status)
    );

    // Register the handler decision as a one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid     <= 1'b0;
            req_handler   <= HND_NONE;
            req_escalated <= 1'b0;
        end else begin
            req_valid     <= accept;
            req_handler   <= accept ? sel_hnd : HND_NONE;
            req_escalated <= accept && sel_esc;
        end
    end
endmodule

// File: rtl/fault_escalation_checks.sv
// Checker for the fault escalation unit, bound to every instance.
// Assumes the encodings stated in the requirements.
module fault_escalation_checks
    import fault_pkg::*;
#(
    parameter int PW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fault_valid,
    input logic [4:0]           fault_cause,
    input logic [PW:0]          cur_pri,
    input logic [2:0]           hnd_en,
    input logic [PW-1:0]        pri_mem,
    input logic [PW-1:0]        pri_bus,
    input logic [PW-1:0]        pri_use,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic [MAXBITS-1:0]   wr_data,
    input logic                 req_valid,
    input logic [2:0]           req_handler,
    input logic                 req_escalated,
    input logic [MEM_BITS-1:0]  mm_status,
    input logic [BUS_BITS-1:0]  bus_status,
    input logic [USE_BITS-1:0]  use_status
);
    logic          c_ok, c_en;
    logic [PW-1:0] c_pri;

    // Reference view of the incoming fault for the properties.
    always_comb begin
        c_ok  = (fault_cause[4:3] == 2'd0 && fault_cause[2:0] < 3'd5) ||
                (fault_cause[4:3] == 2'd1 && fault_cause[2:0] < 3'd6) ||
                (fault_cause[4:3] == 2'd2 && fault_cause[2:0] < 3'd6);
        c_pri = (fault_cause[4:3] == 2'd0) ? pri_mem :
                (fault_cause[4:3] == 2'd1) ? pri_bus : pri_use;
        c_en  = (fault_cause[4:3] == 2'd0) ? hnd_en[0] :
                (fault_cause[4:3] == 2'd1) ? hnd_en[1] : hnd_en[2];
    end

    AST_OWN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && c_ok && c_en && ({1'b0, c_pri} < cur_pri))
        |=> (req_handler == 3'(fault_cause[4:3]) + 3'd1) && !req_escalated); // R6
    AST_ESCALATE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && c_ok && ({1'b0, c_pri} >= cur_pri))
        |=> (req_handler == 3'd4) && req_escalated); // R7
    AST_ESCALATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && c_ok && !c_en) |=> (req_handler == 3'd4)); // R8
    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !c_ok) |=> !req_valid && $stable(mm_status | 5'd0)); // R5
    AST_NO_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |=> !req_valid && (req_handler == 3'd0)); // R12
    AST_MM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd0) |=> ((mm_status & $past(mm_status)) == $past(mm_status))); // R9
    AST_BUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> ((bus_status & $past(bus_status)) == $past(bus_status))); // R9
    AST_USE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd2) |=> ((use_status & $past(use_status)) == $past(use_status))); // R9
    AST_ONE_NEW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({mm_status & ~$past(mm_status), bus_status & ~$past(bus_status),
                              use_status & ~$past(use_status)}) <= 1)); // R2
endmodule

bind fault_escalation_unit fault_escalation_checks #(.PW(PW)) u_chk (.*);

// File: tb/sim_fault_escalation_unit.sv
// Sweeps cause codes, priorities and enables; checks status and requests.
module sim_fault_escalation_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_valid = 1'b0;
    logic [4:0]    fault_cause = '0;
    logic [PW:0]   cur_pri = '0;
    logic [2:0]    hnd_en = '0;
    logic [PW-1:0] pri_mem = '0, pri_bus = '0, pri_use = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [5:0]    wr_data = '0;
    logic          req_valid;
    logic [2:0]    req_handler;
    logic          req_escalated;
    logic [4:0]    mm_status;
    logic [5:0]    bus_status;
    logic [5:0]    use_status;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_escalation_unit #(.PW(PW)) u0 (.*);

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_clr(input logic [1:0] sel, input logic [5:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_fault(input int cat, input int idx);
        @(negedge clk);
        fault_valid = 1'b1;
        fault_cause = 5'((cat << 3) | idx);
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mm_status == 0 && bus_status == 0 && use_status == 0, "R1 status", mm_status, 0);
        check(req_valid == 0 && req_handler == 0, "R1 request", req_handler, 0);
        rst_n = 1'b1;

        // Full sweep: category, index, current level, fault priority, enable.
        for (int cat = 0; cat < 4; cat++) begin
            for (int idx = 0; idx < 8; idx++) begin
                for (int cur = 0; cur < 9; cur++) begin
                    for (int p = 0; p < 8; p++) begin
                        for (int e = 0; e < 2; e++) begin
                            int  width;
                            logic ok;
                            int  exp_h;
                            int  exp_vec;
                            logic [2:0] emask;
                            if (cat == 3 && (cur != 4 || p != 0)) continue;
                            width = (cat == 0) ? 5 : 6;
                            ok = (cat < 3) && (idx < width);
                            emask = (e == 1) ? 3'b111 : (3'b111 & ~(3'b001 << (cat % 3)));
                            exp_h = !ok ? 0 : ((e == 1 && p < cur) ? cat + 1 : 4);
                            exp_vec = ok ? (1 << idx) : 0;
                            @(negedge clk);
                            cur_pri = 4'(cur); hnd_en = emask;
                            pri_mem = 3'(p); pri_bus = 3'(p); pri_use = 3'(p);
                            pulse_fault(cat, idx);
                            check(req_valid == ok, ok ? "R12 request pulse" : "R5 invalid request",
                                  req_valid, ok);
                            if (e == 0) check(req_handler == exp_h, "R8 disabled escalates",
                                              req_handler, exp_h);
                            else if (exp_h == 4) check(req_handler == exp_h && req_escalated,
                                              "R7 escalate to hard", req_handler, exp_h);
                            else check(req_handler == exp_h && !req_escalated,
                                              "R6 own handler", req_handler, exp_h);
                            check(mm_status == ((cat == 0) ? exp_vec : 0), "R2 mem status",
                                  mm_status, (cat == 0) ? exp_vec : 0);
                            check(bus_status == ((cat == 1) ? exp_vec : 0), "R3 bus status",
                                  bus_status, (cat == 1) ? exp_vec : 0);
                            check(use_status == ((cat == 2) ? exp_vec : 0), "R4 usage status",
                                  use_status, (cat == 2) ? exp_vec : 0);
                            @(negedge clk);
                            check(req_valid == 0 && req_handler == 0, "R12 single cycle",
                                  req_valid, 0);
                            write_clr(2'd0, 6'h3f);
                            write_clr(2'd1, 6'h3f);
                            write_clr(2'd2, 6'h3f);
                        end
                    end
                end
            end
        end

        // R9: causes accumulate and persist.
        pulse_fault(0, 0);
        pulse_fault(0, 3);
        repeat (2) @(negedge clk);
        check(mm_status == 5'b01001, "R9 accumulate", mm_status, 5'b01001);

        // R10: zero mask, foreign select, select 3 leave bits alone.
        write_clr(2'd0, 6'h00);
        write_clr(2'd1, 6'h3f);
        write_clr(2'd3, 6'h3f);
        check(mm_status == 5'b01001, "R10 no-effect writes", mm_status, 5'b01001);
        write_clr(2'd0, 6'h01);
        check(mm_status == 5'b01000, "R10 clear one bit", mm_status, 5'b01000);
        write_clr(2'd0, 6'h20);
        check(mm_status == 5'b01000, "R10 bit above width", mm_status, 5'b01000);

        // R11: set and clear of the same bit collide.
        @(negedge clk);
        fault_valid = 1'b1; fault_cause = 5'b10_010;
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 6'b000100;
        @(negedge clk);
        fault_valid = 1'b0; wr_en = 1'b0;
        check(use_status == 6'b000100, "R11 set wins", use_status, 6'b000100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule